// File: doc/BRIEF.md
# LNB Tone Generation Controller

This block produces the on/off drive for the 22 kHz tone that a satellite LNB supply places on its DC output. It also produces the clock for the step-up converter. Both come from one system clock. A prescaler makes the converter clock. The tone is that converter clock divided by twenty, so each tone edge falls on a converter clock rising edge.

Two register bits and one external pin choose the tone source. The continuous-tone bit has top priority and forces a steady tone. When it is clear, the modulation-select bit picks one of two sources:

- **Gated mode** (select bit low): the synchronised pin switches the internal tone on and off. The tone divider restarts on each rising pin edge, so every burst opens with a full high half-cycle.
- **Pass-through mode** (select bit high): the pin already carries a modulated tone, and it goes straight to the output.

When the global enable is low, both outputs are held low and the dividers rest in their idle state.

Top module: `lnb_tone_ctrl`

## Requirements
- R1: While reset is high, and at the first clock edge after it, `tone_o` and `conv_clk_o` are low.
- R2: While `en` is high, `conv_clk_o` has a period of PRE_DIV system clocks. It is high for the first PRE_DIV/2 of them, and the first high phase starts at the first clock edge that samples `en` high.
- R3: With `tone_cont` = 1, `tone_o` is high for 10 converter periods and then low for 10, repeating. Each tone edge coincides with a `conv_clk_o` rising edge, and `mod_pin` has no effect.
- R4: With `tone_cont` = 0 and `mod_sel` = 0, `tone_o` equals the internal tone ANDed with the synchronised `mod_pin`.
- R5: In the mode of R4, a rising edge of the synchronised pin restarts both the converter-clock and the tone dividers. While the pin stays high, `tone_o` is then high for exactly 10 × PRE_DIV system clocks.
- R6: With `tone_cont` = 0 and `mod_sel` = 1, `tone_o` follows the synchronised `mod_pin`, and pin edges do not restart the dividers.
- R7: A change on `mod_pin` reaches `tone_o` three system clock edges after it is sampled: two synchroniser stages and one output register.
- R8: At the first edge that samples `en` low, both outputs go low, and they stay low while `en` is low.
- R9: `tone_cont` = 1 takes priority over `mod_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable for the tone and converter clock |
| tone_cont | input | 1 | Register bit: continuous tone |
| mod_sel | input | 1 | Register bit: pin carries an already modulated tone |
| mod_pin | input | 1 | Asynchronous external modulation pin |
| tone_o | output | 1 | Registered tone drive |
| conv_clk_o | output | 1 | Registered converter clock, 20 × tone frequency |

## Verification
The hardest case to reach is a pin rising edge in gated mode that lands part-way through a converter period and part-way through a tone half-cycle. Only that case shows the divider restart and the shortened converter period around it.

The stimulus therefore drives gated bursts of varying length and spacing, so that pin edges fall at many prescaler and tone phases. A directed burst then checks that the first high phase lasts exactly 10 × PRE_DIV clocks.

Pass-through edges are sent during steady tone to show that they cause no restart. The enable is also dropped mid-period.

// File: rtl/lnb_tone_pkg.sv
package lnb_tone_pkg;
  typedef enum logic [1:0] {
    MODE_CONT  = 2'd0,
    MODE_GATED = 2'd1,
    MODE_PASS  = 2'd2
  } tone_mode_e;

  function automatic tone_mode_e pick_mode(input logic cont, input logic sel);
    if (cont)     return MODE_CONT;
    else if (sel) return MODE_PASS;
    else          return MODE_GATED;
  endfunction
endpackage

// File: rtl/lnb_sync.sv
module lnb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lnb_prescale.sv
module lnb_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic conv_clk_o,
  output logic period_start
);
  localparam int PW   = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int HALF = PRE_DIV / 2;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pcnt, pcnt_nx;

  always_comb begin
    if (!en)               pcnt_nx = LAST;
    else if (restart)      pcnt_nx = '0;
    else if (pcnt == LAST) pcnt_nx = '0;
    else                   pcnt_nx = pcnt + 1'b1;
  end

  assign period_start = en && (pcnt_nx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt       <= LAST;
      conv_clk_o <= 1'b0;
    end else begin
      pcnt       <= pcnt_nx;
      conv_clk_o <= en && (pcnt_nx < PW'(HALF));
    end
  end

  p_pcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    pcnt <= LAST);
  p_clk_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (en && period_start) |=> conv_clk_o);
endmodule

// File: rtl/lnb_tone_div.sv
module lnb_tone_div #(
  parameter int TONE_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  input  logic period_start,
  output logic tone_hi_nx
);
  localparam int TW = $clog2(TONE_DIV);
  localparam logic [TW-1:0] LAST = TW'(TONE_DIV - 1);
  localparam logic [TW-1:0] HALF = TW'(TONE_DIV / 2);

  logic [TW-1:0] tcnt, tcnt_nx;

  always_comb begin
    if (!en)               tcnt_nx = LAST;
    else if (restart)      tcnt_nx = '0;
    else if (period_start) tcnt_nx = (tcnt == LAST) ? '0 : tcnt + 1'b1;
    else                   tcnt_nx = tcnt;
  end

  assign tone_hi_nx = tcnt_nx < HALF;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= LAST;
    else     tcnt <= tcnt_nx;
  end

  p_tcnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    tcnt <= LAST);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !restart && !period_start) |=> (tcnt == $past(tcnt)));
endmodule

// File: rtl/lnb_tone_ctrl.sv
module lnb_tone_ctrl
  import lnb_tone_pkg::*;
#(
  parameter int PRE_DIV     = 4,
  parameter int TONE_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tone_cont,
  input  logic mod_sel,
  input  logic mod_pin,
  output logic tone_o,
  output logic conv_clk_o
);
  tone_mode_e mode;
  logic pin_s, pin_d, pin_rise, restart, period_start, tone_hi_nx, tone_sel;

  lnb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(mod_pin), .q_o(pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  assign mode     = pick_mode(tone_cont, mod_sel);
  assign pin_rise = pin_s && !pin_d;
  assign restart  = en && (mode == MODE_GATED) && pin_rise;

  lnb_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .en(en), .restart(restart),
    .conv_clk_o(conv_clk_o), .period_start(period_start)
  );

  lnb_tone_div #(.TONE_DIV(TONE_DIV)) u_tdiv (
    .clk(clk), .rst(rst), .en(en), .restart(restart),
    .period_start(period_start), .tone_hi_nx(tone_hi_nx)
  );

  always_comb begin
    case (mode)
      MODE_CONT:  tone_sel = tone_hi_nx;
      MODE_PASS:  tone_sel = pin_s;
      default:    tone_sel = pin_s && tone_hi_nx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tone_o <= 1'b0;
    else     tone_o <= en && tone_sel;
  end

  p_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tone_o && !conv_clk_o));
  p_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !tone_cont && mod_sel) |=> (tone_o == $past(pin_s)));
  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !tone_cont && !mod_sel && !pin_s) |=> !tone_o);
  p_burst_start_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tone_o && conv_clk_o));
endmodule

// File: tb/tb_lnb_tone_ctrl.sv
module tb_lnb_tone_ctrl;
  localparam int P = 4;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, tone_cont = 1'b0, mod_sel = 1'b0, mod_pin = 1'b0;
  logic tone_o, conv_clk_o;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  string req = "R1";

  lnb_tone_ctrl #(.PRE_DIV(P), .TONE_DIV(T)) dut (
    .clk(clk), .rst(rst), .en(en), .tone_cont(tone_cont), .mod_sel(mod_sel),
    .mod_pin(mod_pin), .tone_o(tone_o), .conv_clk_o(conv_clk_o)
  );

  always #2 clk = ~clk;

  // Behavioural reference: pin sample history and two phase counters
  int m_p = P - 1, m_t = T - 1;
  bit m_hist[$];
  bit m_prev = 1'b0;
  bit m_tone = 1'b0, m_clk = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_p = P - 1; m_t = T - 1; m_prev = 0; m_tone = 0; m_clk = 0;
      m_hist = {1'b0, 1'b0};
    end else begin
      bit s, rise, rs, hi, sel;
      int np, nt;
      s = m_hist[0];
      rise = s && !m_prev;
      rs = en && !tone_cont && !mod_sel && rise;
      if (!en) np = P - 1; else if (rs) np = 0; else np = (m_p + 1) % P;
      if (!en) nt = T - 1; else if (rs) nt = 0;
      else if (np == 0) nt = (m_t + 1) % T; else nt = m_t;
      hi = nt < T / 2;
      if (tone_cont) sel = hi; else if (mod_sel) sel = s; else sel = s && hi;
      m_tone = en && sel;
      m_clk = en && (np < P / 2);
      m_prev = s;
      void'(m_hist.pop_front());
      m_hist.push_back(mod_pin);
      m_p = np; m_t = nt;
    end
  end

  task automatic check(input string r, input logic act, input logic exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", r, what, cyc, act, exp);
    end
  endtask

  bit cmp_on = 1'b0;
  always @(negedge clk) if (cmp_on) begin
    check(req, tone_o, m_tone, "tone_o");
    check("R2", conv_clk_o, m_clk, "conv_clk_o");
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(3);
    check("R1", tone_o, 1'b0, "tone_o in reset");
    check("R1", conv_clk_o, 1'b0, "conv_clk_o in reset");
    rst = 1'b0;
    step(1);
    check("R1", tone_o, 1'b0, "tone_o after reset");
    cmp_on = 1'b1;

    // R3: continuous tone, pin toggling ignored
    req = "R3"; tone_cont = 1'b1; en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 0) mod_pin = ~mod_pin;
      step(1);
    end

    // R4/R5: gated bursts at varying phases
    req = "R4"; tone_cont = 1'b0; mod_sel = 1'b0; mod_pin = 1'b0;
    step(5);
    for (int b = 0; b < 12; b++) begin
      req = "R5"; mod_pin = 1'b1; step(30 + 13 * b);
      req = "R4"; mod_pin = 1'b0; step(7 + 5 * b);
    end

    // R5 directed: first high phase lasts 10*P clocks
    begin
      int hi_len = 0;
      mod_pin = 1'b0; step(10);
      mod_pin = 1'b1; step(3);
      while (tone_o === 1'b1 && hi_len < 200) begin hi_len++; step(1); end
      check("R5", (hi_len == (T / 2) * P), 1'b1, "burst first high length");
      mod_pin = 1'b0; step(5);
    end

    // R6/R7: pass-through, no restart
    req = "R6"; mod_sel = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (i % 11 == 3) mod_pin = ~mod_pin;
      step(1);
    end
    begin
      mod_pin = 1'b0; step(5);
      mod_pin = 1'b1;
      step(2); check("R7", tone_o, 1'b0, "pass latency two edges");
      step(1); check("R7", tone_o, 1'b1, "pass latency three edges");
    end

    // R9: continuous beats select
    req = "R9"; tone_cont = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (i % 9 == 0) mod_pin = ~mod_pin;
      step(1);
    end

    // R8: enable dropped mid-period, then restored
    req = "R8"; step(3); en = 1'b0;
    step(1);
    check("R8", tone_o, 1'b0, "tone_o with en low");
    check("R8", conv_clk_o, 1'b0, "conv_clk_o with en low");
    step(20);
    req = "R2"; en = 1'b1;
    step(1);
    check("R2", conv_clk_o, 1'b1, "conv_clk_o first enabled edge");
    step(300);

    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule